// File: doc/BRIEF.md
# Mixed-Clock Cell-Array FIFO

This block carries 32-bit words from a sender to a receiver that run on two unrelated clocks. It holds four storage cells arranged as a ring. Each cell has one status flag bit kept in the put domain and one kept in the get domain, and the cell counts as occupied when the two bits differ. A one-hot write token picks the cell for the next put and a one-hot read token picks the cell for the next get. Each token moves one place around the ring for every transfer accepted in its own clock domain. No binary or Gray pointers cross between the domains. Only the per-cell flag bits cross, and each crossing uses a two-flop synchronizer.

Each side has a detector and a controller. The put-side detector counts free cells in its own view and raises `put_full` early: once only one cell remains free. The put controller accepts a word only when `put_full` is low. The get-side detector counts occupied cells and raises `get_empty` once at most one word remains. The get controller also has an exact occupancy check, so it can still hand out the last word while `get_empty` is high. The receiver knows a read happened from `get_valid`, which is high only in the cycle after a read was performed. `get_data` keeps its value in every other cycle.

Top module: `xcf_cell_fifo`

## Requirements
- R1: While `rst_n` is low, `put_full` is 0, `get_empty` is 1, `get_valid` is 0 and `get_data` is 0.
- R2: A word is taken only on a `put_clk` rising edge where `put_req` is 1 and `put_full` is 0. Starting from empty, `put_full` goes to 1 right after the third accepted word. A fourth request is then refused, so no word is lost or overwritten.
- R3: When the put side is full and one word is read, `put_full` stays 1 after the first `put_clk` edge that follows the read edge. It goes to 0 after the second such edge.
- R4: `get_empty` is 1 whenever the get side sees at most one stored word. After the put that brings the count to two, `get_empty` is still 1 after the first following `get_clk` edge and is 0 after the second.
- R5: A read is performed on a `get_clk` edge when `get_req` is 1 and the get side sees at least one stored word. This includes the last word while `get_empty` is 1.
- R6: `get_valid` is 1 in the `get_clk` cycle right after a performed read, and only then. In that cycle `get_data` carries the word read.
- R7: While `get_valid` is 0, `get_data` keeps its previous value.
- R8: Words leave in the order they were accepted, with no loss and no duplication, at get clock periods shorter than, equal to or longer than the put clock period.
- R9: A read request when no word is stored does not perform a read: `get_valid` stays 0.
- R10: Reset applied while words are stored discards them and returns both tokens to cell 0. The first word written after reset is the first word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| put_clk | input | 1 | Sender clock |
| get_clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| put_req | input | 1 | Sender wants to store `put_data` |
| put_data | input | 32 | Word to store |
| put_full | output | 1 | Early full warning; requests are refused while it is high |
| get_req | input | 1 | Receiver wants a word |
| get_data | output | 32 | Last word read |
| get_valid | output | 1 | A read was performed on the previous `get_clk` edge |
| get_empty | output | 1 | At most one word is visible to the get side |

## Verification
Several results appear on different edges. `put_full` rises in the same `put_clk` edge that accepts the third word, and falls on the second `put_clk` edge after the get edge that frees a cell. `get_empty` falls on the second `get_clk` edge after the put that makes two words visible. `get_valid` and `get_data` follow a request by exactly one `get_clk` edge. In the directed part, the bench gives the two clocks fixed phases, so edges never coincide. It samples 0.2 ns after the edge under test, before the other clock can tick, and counts edges of the right clock before each check. In the streaming sweeps, only order, hold and request-before-valid rules are checked. Those rules hold whatever the phase between the clocks.

// File: rtl/xcf_pkg.sv
`timescale 1ns/1ps
package xcf_pkg;

  // Minimum synchronizer depth accepted by the block.
  localparam int SYNC_MIN = 2;

  // Number of set bits in a vector of up to 64 cells.
  function automatic int unsigned ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      n += {31'd0, v[i]};
    end
    return n;
  endfunction

endpackage

// File: rtl/xcf_rst_sync.sv
`timescale 1ns/1ps
module xcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/xcf_sync_vec.sv
`timescale 1ns/1ps
module xcf_sync_vec #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  always_comb begin
    st_d = {st_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/xcf_put_ctrl.sv
`timescale 1ns/1ps
module xcf_put_ctrl #(
  parameter int CELLS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CELLS-1:0] peer_flags,
  output logic [CELLS-1:0] own_flags,
  output logic [CELLS-1:0] wr_sel,
  output logic [CELLS-1:0] tok,
  output logic             full
);
  import xcf_pkg::*;
  localparam int CNT_W  = $clog2(CELLS + 1);
  localparam int MARGIN = 1;

  logic [CELLS-1:0] peer_s;
  logic [CELLS-1:0] tok_q, tok_d;
  logic [CELLS-1:0] flg_q, flg_d;
  logic [CNT_W-1:0] free_cnt;
  logic             put_ok;

  xcf_sync_vec #(.W(CELLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(peer_flags), .q(peer_s)
  );

  // Free-cell detector: a stale peer view only makes cells look occupied.
  always_comb begin
    free_cnt = CNT_W'(CELLS - ones(64'(flg_q ^ peer_s)));
    full     = (free_cnt <= CNT_W'(MARGIN));
    put_ok   = req && !full;
    tok_d    = tok_q;
    flg_d    = flg_q;
    if (put_ok) begin
      tok_d = {tok_q[CELLS-2:0], tok_q[CELLS-1]};
      flg_d = flg_q ^ tok_q;
    end
    wr_sel = put_ok ? tok_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= CELLS'(1);
      flg_q <= '0;
    end else begin
      tok_q <= tok_d;
      flg_q <= flg_d;
    end
  end

  assign own_flags = flg_q;
  assign tok       = tok_q;
endmodule

// File: rtl/xcf_get_ctrl.sv
`timescale 1ns/1ps
module xcf_get_ctrl #(
  parameter int CELLS       = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(CELLS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req,
  input  logic [CELLS-1:0]              peer_flags,
  input  logic [CELLS-1:0][DATA_W-1:0]  cells,
  output logic [CELLS-1:0]              own_flags,
  output logic [DATA_W-1:0]             data,
  output logic                          valid,
  output logic                          empty,
  output logic [CNT_W-1:0]              used
);
  import xcf_pkg::*;
  localparam int MARGIN = 1;

  logic [CELLS-1:0]  peer_s;
  logic [CELLS-1:0]  tok_q, tok_d;
  logic [CELLS-1:0]  flg_q, flg_d;
  logic [DATA_W-1:0] data_q, data_d, rd_word;
  logic              valid_q, valid_d;
  logic              get_ok;

  xcf_sync_vec #(.W(CELLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(peer_flags), .q(peer_s)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (tok_q[i]) rd_word |= cells[i];
    end
  end

  // Occupancy detector plus exact check for the final word.
  always_comb begin
    used    = CNT_W'(ones(64'(flg_q ^ peer_s)));
    empty   = (used <= CNT_W'(MARGIN));
    get_ok  = req && (!empty || (used != '0));
    tok_d   = tok_q;
    flg_d   = flg_q;
    data_d  = data_q;
    valid_d = get_ok;
    if (get_ok) begin
      tok_d  = {tok_q[CELLS-2:0], tok_q[CELLS-1]};
      flg_d  = flg_q ^ tok_q;
      data_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q   <= CELLS'(1);
      flg_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      tok_q   <= tok_d;
      flg_q   <= flg_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign own_flags = flg_q;
  assign data      = data_q;
  assign valid     = valid_q;
endmodule

// File: rtl/xcf_cell_fifo.sv
`timescale 1ns/1ps
module xcf_cell_fifo #(
  parameter int DATA_W      = 32,
  parameter int CELLS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              put_clk,
  input  logic              get_clk,
  input  logic              rst_n,
  input  logic              put_req,
  input  logic [DATA_W-1:0] put_data,
  output logic              put_full,
  input  logic              get_req,
  output logic [DATA_W-1:0] get_data,
  output logic              get_valid,
  output logic              get_empty
);
  localparam int CNT_W = $clog2(CELLS + 1);

  logic                         put_rst_n, get_rst_n;
  logic [CELLS-1:0]             put_flags, get_flags;
  logic [CELLS-1:0]             wr_sel;
  logic [CELLS-1:0]             put_tok;
  logic [CNT_W-1:0]             get_used;
  logic [CELLS-1:0][DATA_W-1:0] cell_q, cell_d;

  xcf_rst_sync #(.STAGES(SYNC_STAGES)) u_put_rst (
    .clk(put_clk), .rst_an(rst_n), .rst_n_o(put_rst_n)
  );
  xcf_rst_sync #(.STAGES(SYNC_STAGES)) u_get_rst (
    .clk(get_clk), .rst_an(rst_n), .rst_n_o(get_rst_n)
  );

  xcf_put_ctrl #(.CELLS(CELLS), .SYNC_STAGES(SYNC_STAGES)) u_put (
    .clk(put_clk), .rst_n(put_rst_n), .req(put_req),
    .peer_flags(get_flags), .own_flags(put_flags),
    .wr_sel(wr_sel), .tok(put_tok), .full(put_full)
  );

  // Cell storage: written in the put domain, read only while flagged occupied.
  always_comb begin
    cell_d = cell_q;
    for (int i = 0; i < CELLS; i++) begin
      if (wr_sel[i]) cell_d[i] = put_data;
    end
  end

  always_ff @(posedge put_clk) begin
    if (|wr_sel) cell_q <= cell_d;
  end

  xcf_get_ctrl #(.CELLS(CELLS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_get (
    .clk(get_clk), .rst_n(get_rst_n), .req(get_req),
    .peer_flags(put_flags), .cells(cell_q), .own_flags(get_flags),
    .data(get_data), .valid(get_valid), .empty(get_empty), .used(get_used)
  );
endmodule

// File: rtl/xcf_cell_fifo_chk.sv
`timescale 1ns/1ps
module xcf_cell_fifo_chk #(
  parameter int CELLS  = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input logic              put_clk,
  input logic              get_clk,
  input logic              rst_n,
  input logic              put_full,
  input logic [CELLS-1:0]  put_tok,
  input logic              get_req,
  input logic              get_valid,
  input logic              get_empty,
  input logic [CNT_W-1:0]  get_used,
  input logic [DATA_W-1:0] get_data
);
  // R2: a raised full flag freezes the write token.
  a_r2_no_overflow: assert property (@(posedge put_clk) disable iff (!rst_n)
    put_full |=> $stable(put_tok));

  // R10: the write token is always a single cell.
  a_r10_token_onehot: assert property (@(posedge put_clk) disable iff (!rst_n)
    $countones(put_tok) == 1);

  // R5: a request with two or more visible words is served next cycle.
  a_r5_read_served: assert property (@(posedge get_clk) disable iff (!rst_n)
    (get_req && !get_empty) |=> get_valid);

  // R6: valid only follows a request.
  a_r6_valid_needs_req: assert property (@(posedge get_clk) disable iff (!rst_n)
    get_valid |-> $past(get_req));

  // R7: data holds while valid is low.
  a_r7_data_hold: assert property (@(posedge get_clk) disable iff (!rst_n)
    !get_valid |-> $stable(get_data));

  // R9: nothing stored means no read.
  a_r9_no_underflow: assert property (@(posedge get_clk) disable iff (!rst_n)
    (get_used == '0) |=> !get_valid);
endmodule

bind xcf_cell_fifo xcf_cell_fifo_chk #(
  .CELLS(CELLS), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .put_clk(put_clk), .get_clk(get_clk), .rst_n(rst_n),
  .put_full(put_full), .put_tok(put_tok), .get_req(get_req),
  .get_valid(get_valid), .get_empty(get_empty), .get_used(get_used),
  .get_data(get_data)
);

// File: tb/test_xcf_cell_fifo.sv
`timescale 1ns/1ps
module test_xcf_cell_fifo;
  localparam int DW = 32;
  localparam int N  = 60;

  logic clk_p = 1'b0;
  logic clk_g = 1'b0;
  realtime g_half = 5.0;

  logic          rst_n;
  logic          put_req;
  logic [DW-1:0] put_data;
  logic          put_full;
  logic          get_req;
  logic [DW-1:0] get_data;
  logic          get_valid;
  logic          get_empty;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_data;

  always #2 clk_p = ~clk_p;
  initial begin
    #0.7;
    forever begin
      #(g_half);
      clk_g = ~clk_g;
    end
  end

  xcf_cell_fifo i_xcf_cell_fifo (
    .put_clk(clk_p), .get_clk(clk_g), .rst_n(rst_n),
    .put_req(put_req), .put_data(put_data), .put_full(put_full),
    .get_req(get_req), .get_data(get_data), .get_valid(get_valid),
    .get_empty(get_empty)
  );

  function automatic logic [DW-1:0] word_of(input int phase, input int k);
    return {8'(phase + 8'hA0), 24'(k * 7 + 3)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic put_word(input logic [DW-1:0] w, output bit took);
    bit f;
    put_req  = 1'b1;
    put_data = w;
    f = put_full;
    @(posedge clk_p);
    took = !f;
    if (took) exp_q.push_back(w);
    #0.2;
    put_req = 1'b0;
  endtask

  task automatic expect_read(input string tag);
    logic [DW-1:0] w;
    chk(get_valid == 1'b1, {tag, " valid"}, 32'(get_valid), 32'd1);
    w = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
    chk(get_data == w, {tag, " data"}, get_data, w);
    last_data = get_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(put_full == 1'b0, "R1 full low in reset", 32'(put_full), 32'd0);
    chk(get_empty == 1'b1, "R1 empty high in reset", 32'(get_empty), 32'd1);
    chk(get_valid == 1'b0, "R1 valid low in reset", 32'(get_valid), 32'd0);
    chk(get_data == '0, "R1 data zero in reset", get_data, '0);
    exp_q.delete();
    last_data = '0;
    repeat (3) @(posedge clk_g);
    @(posedge clk_p);
    #0.2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk_g);
    @(posedge clk_p);
    #0.2;
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    bit took;
    int n;
    rst_n = 1'b0; put_req = 1'b0; put_data = '0; get_req = 1'b0;
    last_data = '0;
    #3;
    do_reset();

    // R2: fill from empty; full after the third accepted word
    n = 0;
    for (int k = 0; k < 4; k++) begin
      put_word(word_of(0, k), took);
      n += took ? 1 : 0;
      chk(put_full == (n >= 3), "R2 full flag after write", 32'(put_full), 32'(n >= 3));
    end
    chk(n == 3, "R2 fourth request refused", 32'(n), 32'd3);

    repeat (4) @(posedge clk_g);
    #0.2;
    chk(get_empty == 1'b0, "R4 empty low with three words", 32'(get_empty), 32'd0);

    // R3: one read frees a cell; full falls on the second put edge
    get_req = 1'b1;
    @(posedge clk_g);
    #0.2;
    get_req = 1'b0;
    expect_read("R6 first read");
    chk(get_empty == 1'b0, "R4 empty low with two words", 32'(get_empty), 32'd0);
    @(posedge clk_p);
    #0.2;
    chk(put_full == 1'b1, "R3 full held after first put edge", 32'(put_full), 32'd1);
    @(posedge clk_p);
    #0.2;
    chk(put_full == 1'b0, "R3 full low after second put edge", 32'(put_full), 32'd0);

    // R5 last word under empty, R9 bare request, R7 hold
    get_req = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(posedge clk_g);
      #0.2;
      if (j < 2) begin
        expect_read("R5 read down to last word");
        chk(get_empty == 1'b1, "R4 empty high at one or zero words", 32'(get_empty), 32'd1);
      end else begin
        chk(get_valid == 1'b0, "R9 no read when bare", 32'(get_valid), 32'd0);
        chk(get_data == last_data, "R7 data held", get_data, last_data);
      end
    end
    get_req = 1'b0;

    // R4: empty falls on the second get edge after the second word
    @(posedge clk_p);
    #0.2;
    put_word(word_of(1, 0), took);
    put_word(word_of(1, 1), took);
    @(posedge clk_g);
    #0.2;
    chk(get_empty == 1'b1, "R4 empty held after first get edge", 32'(get_empty), 32'd1);
    @(posedge clk_g);
    #0.2;
    chk(get_empty == 1'b0, "R4 empty low after second get edge", 32'(get_empty), 32'd0);
    get_req = 1'b1;
    for (int j = 0; j < 2; j++) begin
      @(posedge clk_g);
      #0.2;
      expect_read("R8 drain");
    end
    get_req = 1'b0;

    // R10: reset with words stored
    @(posedge clk_p);
    #0.2;
    put_word(word_of(2, 0), took);
    put_word(word_of(2, 1), took);
    repeat (4) @(posedge clk_g);
    do_reset();
    put_word(word_of(3, 0), took);
    repeat (4) @(posedge clk_g);
    #0.2;
    get_req = 1'b1;
    @(posedge clk_g);
    #0.2;
    get_req = 1'b0;
    expect_read("R10 first word after reset");

    // R8: streaming sweeps over three clock ratios
    for (int p = 0; p < 3; p++) begin
      g_half = (p == 0) ? 1.5 : ((p == 1) ? 5.0 : 3.3);
      repeat (4) @(posedge clk_g);
      @(posedge clk_p);
      #0.2;
      fork
        begin : sender
          int c;
          int k;
          bit r;
          bit f;
          c = 0;
          k = 0;
          while (k < N) begin
            r = (c % 5) != 3;
            put_req  = r;
            put_data = word_of(p + 4, k);
            f = put_full;
            @(posedge clk_p);
            if (r && !f) begin
              exp_q.push_back(put_data);
              k++;
            end
            #0.2;
            c++;
          end
          put_req = 1'b0;
        end
        begin : receiver
          int got;
          int j;
          bit pr;
          logic [DW-1:0] w;
          got = 0;
          j = 0;
          pr = 1'b0;
          get_req = 1'b0;
          while (got < N) begin
            @(posedge clk_g);
            #0.2;
            if (get_valid) begin
              chk(pr, "R6 valid follows request", 32'(pr), 32'd1);
              w = (exp_q.size() > 0) ? exp_q.pop_front() : ~get_data;
              chk(get_data == w, "R8 stream order", get_data, w);
              last_data = get_data;
              got++;
            end else begin
              chk(get_data == last_data, "R7 stream hold", get_data, last_data);
            end
            j++;
            pr = ((j * 5 + p) % 7) != 0;
            get_req = pr;
          end
          get_req = 1'b0;
        end
      join
      repeat (6) @(posedge clk_g);
      #0.2;
      chk(exp_q.size() == 0, "R8 nothing left over", 32'(exp_q.size()), 32'd0);
      chk(get_valid == 1'b0, "R9 idle after stream", 32'(get_valid), 32'd0);
    end
    summary();
  end
endmodule